// File: doc/BRIEF.md
# Register Status Rename Table

This block pairs an architectural register file with a per-register status table. The status table records, for each register, whether its newest value is already in the file or is still owed by an in-flight operation, and in the second case which tag will deliver it. An issue stage presents two source register numbers and gets back, in the same cycle, either a ready value or the producer tag for each. The same issue beat may name a destination register, and that register's status entry is then overwritten with the new operation's tag.

Finished operations announce themselves on a result broadcast bus as a tag and a data word. The block snoops that bus. A register takes the broadcast data only when its status entry still names exactly that tag. After the write the entry returns to the ready state. A result from an older writer whose entry has since been renamed is dropped. Write-after-write ordering therefore needs no stall. Each tag carries an epoch bit in its most significant position, so that a recycled tag index is never mistaken for an older use of the same index. A flush input returns every status entry to the ready state. Register zero is hard-wired as ready with value zero and is never renamed.

The issue beat and the broadcast beat are each qualified by a valid input, and both are accepted in the cycle they are presented. The block never applies back-pressure. It therefore has no ready output, and the upstream stages must not expect to be held. The source lookups are combinational and need no valid.

Top module: `rst_rename_table`

## Requirements
- R1: After reset every register reads ready with value zero on both source ports.
- R2: An issue beat with destination write enabled to register d with tag t makes later reads of d return not-ready with tag t, until a matching broadcast arrives.
- R3: A second rename of a register that is still pending replaces the older tag, and later readers receive the newest tag.
- R4: A broadcast whose tag equals a register's status tag writes the broadcast data into that register and makes it ready from the next cycle. Other pending registers are unaffected.
- R5: A broadcast whose tag differs from a register's status tag leaves that register pending with its current tag, and its data never reaches that register.
- R6: Tags are compared on all bits, including the epoch bit (the most significant tag bit). Two tags that differ only in the epoch bit do not match.
- R7: A source read of a pending register, in the same cycle as a broadcast matching its tag, returns ready with the broadcast data.
- R8: If a destination rename and a matching broadcast hit the same register in one cycle, the register is left pending with the new tag.
- R9: A flush makes every register read ready from the next cycle and takes priority over a rename in the same cycle. A later broadcast of a tag that was pending before the flush writes nothing.
- R10: Register zero always reads ready with value zero. A rename or broadcast aimed at it has no effect.
- R11: A source read of register d in the same cycle as a rename of d returns the status from before the rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clears every status entry to ready |
| iss_valid | input | 1 | Issue beat present (qualifies the destination write) |
| iss_dst_we | input | 1 | Issue beat writes a destination register |
| iss_src_a | input | IDX_W | First source register number |
| iss_src_b | input | IDX_W | Second source register number |
| iss_dst | input | IDX_W | Destination register number |
| iss_tag | input | TAG_W | Tag of the issuing operation; MSB is the epoch bit |
| bcast_valid | input | 1 | Result broadcast present |
| bcast_tag | input | TAG_W | Tag of the broadcast result |
| bcast_data | input | DATA_W | Broadcast result value |
| src_a_ready | output | 1 | First source value is available |
| src_a_value | output | DATA_W | First source value (zero when not ready) |
| src_a_tag | output | TAG_W | First source producer tag (zero when ready) |
| src_b_ready | output | 1 | Second source value is available |
| src_b_value | output | DATA_W | Second source value (zero when not ready) |
| src_b_tag | output | TAG_W | Second source producer tag (zero when ready) |

## Verification
The main lookup is tried with a sweep that renames every register. Their tags are then retired in reverse order, and after each broadcast all registers are read back. This separates a correct per-register match from one that wakes neighbours or misses. Stale broadcasts, tags that differ only in the epoch bit, and a broadcast that coincides with a rename or with a read of the same register separate the tag comparison from a simple index or pending check. A flush followed by a broadcast of a formerly pending tag separates clearing the status from leaving the owed write armed.

// File: rtl/rst_pkg.sv
package rst_pkg;

  typedef enum logic {
    ENT_READY   = 1'b0,
    ENT_PENDING = 1'b1
  } ent_state_e;

  localparam int unsigned NUM_SRC_PORTS = 2;

endpackage

// File: rtl/rst_status_table.sv
module rst_status_table
  import rst_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned TAG_W    = 5,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           set_en,
  input  logic [IDX_W-1:0]               set_idx,
  input  logic [TAG_W-1:0]               set_tag,
  input  logic                           bcast_valid,
  input  logic [TAG_W-1:0]               bcast_tag,
  output logic [NUM_REGS-1:0]            pend,
  output logic [NUM_REGS-1:0][TAG_W-1:0] tags,
  output logic [NUM_REGS-1:0]            hit
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign pend[i] = 1'b0;
      assign tags[i] = '0;
      assign hit[i]  = 1'b0;
    end else begin : g_live
      ent_state_e       state_q;
      logic [TAG_W-1:0] tag_q;
      logic             sel;

      assign sel     = set_en && (set_idx == IDX_W'(i));
      assign pend[i] = (state_q == ENT_PENDING);
      assign tags[i] = tag_q;
      assign hit[i]  = pend[i] && bcast_valid && (tag_q == bcast_tag);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          state_q <= ENT_READY;
          tag_q   <= '0;
        end else if (flush) begin
          state_q <= ENT_READY;
        end else if (sel) begin
          state_q <= ENT_PENDING;
          tag_q   <= set_tag;
        end else if (hit[i]) begin
          state_q <= ENT_READY;
        end
      end
    end
  end

endmodule

// File: rtl/rst_regfile.sv
module rst_regfile #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_REGS-1:0]             we,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0] vals
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    assign vals[i] = val_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (we[i]) begin
        val_q <= wdata;
      end
    end
  end

endmodule

// File: rtl/rst_src_port.sv
module rst_src_port #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TAG_W    = 5,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]                src,
  input  logic [NUM_REGS-1:0]             pend,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]  tags,
  input  logic [NUM_REGS-1:0]             hit,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] vals,
  input  logic [DATA_W-1:0]               bcast_data,
  output logic                            ready,
  output logic [DATA_W-1:0]               value,
  output logic [TAG_W-1:0]                tag
);

  always_comb begin
    ready = 1'b1;
    value = '0;
    tag   = '0;
    if (src == '0) begin
      ready = 1'b1;
    end else if (!pend[src]) begin
      value = vals[src];
    end else if (hit[src]) begin
      value = bcast_data;
    end else begin
      ready = 1'b0;
      tag   = tags[src];
    end
  end

endmodule

// File: rtl/rst_rename_table.sv
module rst_rename_table
  import rst_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TAG_IDX_W = 4,
  localparam int unsigned TAG_W    = TAG_IDX_W + 1,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              iss_valid,
  input  logic              iss_dst_we,
  input  logic [IDX_W-1:0]  iss_src_a,
  input  logic [IDX_W-1:0]  iss_src_b,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              bcast_valid,
  input  logic [TAG_W-1:0]  bcast_tag,
  input  logic [DATA_W-1:0] bcast_data,
  output logic              src_a_ready,
  output logic [DATA_W-1:0] src_a_value,
  output logic [TAG_W-1:0]  src_a_tag,
  output logic              src_b_ready,
  output logic [DATA_W-1:0] src_b_value,
  output logic [TAG_W-1:0]  src_b_tag
);

  logic [NUM_REGS-1:0]             pend;
  logic [NUM_REGS-1:0][TAG_W-1:0]  tags;
  logic [NUM_REGS-1:0]             hit;
  logic [NUM_REGS-1:0][DATA_W-1:0] vals;
  logic                            rename_en;

  assign rename_en = iss_valid && iss_dst_we;

  rst_status_table #(
    .NUM_REGS (NUM_REGS),
    .TAG_W    (TAG_W)
  ) status_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .set_en      (rename_en),
    .set_idx     (iss_dst),
    .set_tag     (iss_tag),
    .bcast_valid (bcast_valid),
    .bcast_tag   (bcast_tag),
    .pend        (pend),
    .tags        (tags),
    .hit         (hit)
  );

  rst_regfile #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (hit),
    .wdata (bcast_data),
    .vals  (vals)
  );

  logic [NUM_SRC_PORTS-1:0][IDX_W-1:0]  p_src;
  logic [NUM_SRC_PORTS-1:0]             p_ready;
  logic [NUM_SRC_PORTS-1:0][DATA_W-1:0] p_value;
  logic [NUM_SRC_PORTS-1:0][TAG_W-1:0]  p_tag;

  assign p_src[0] = iss_src_a;
  assign p_src[1] = iss_src_b;

  for (genvar p = 0; p < NUM_SRC_PORTS; p++) begin : g_port
    rst_src_port #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .TAG_W    (TAG_W)
    ) port_i (
      .src        (p_src[p]),
      .pend       (pend),
      .tags       (tags),
      .hit        (hit),
      .vals       (vals),
      .bcast_data (bcast_data),
      .ready      (p_ready[p]),
      .value      (p_value[p]),
      .tag        (p_tag[p])
    );
  end

  assign src_a_ready = p_ready[0];
  assign src_a_value = p_value[0];
  assign src_a_tag   = p_tag[0];
  assign src_b_ready = p_ready[1];
  assign src_b_value = p_value[1];
  assign src_b_tag   = p_tag[1];

endmodule

// File: rtl/rst_rename_table_chk.sv
module rst_rename_table_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 5,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              iss_valid,
  input logic              iss_dst_we,
  input logic [IDX_W-1:0]  iss_src_a,
  input logic [IDX_W-1:0]  iss_src_b,
  input logic [IDX_W-1:0]  iss_dst,
  input logic [TAG_W-1:0]  iss_tag,
  input logic              bcast_valid,
  input logic [TAG_W-1:0]  bcast_tag,
  input logic [DATA_W-1:0] bcast_data,
  input logic              src_a_ready,
  input logic [DATA_W-1:0] src_a_value,
  input logic [TAG_W-1:0]  src_a_tag,
  input logic              src_b_ready,
  input logic [DATA_W-1:0] src_b_value,
  input logic [TAG_W-1:0]  src_b_tag
);

  assert_zero_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_src_a == '0) |-> (src_a_ready && src_a_value == '0));

  assert_zero_reg_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_src_b == '0) |-> (src_b_ready && src_b_value == '0));

  assert_flush_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (src_a_ready && src_b_ready));

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !src_a_ready |-> !(bcast_valid && bcast_tag == src_a_tag));

  assert_bypass_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !src_b_ready |-> !(bcast_valid && bcast_tag == src_b_tag));

  // R2, R3 and R8: a rename is visible on the next cycle with the new tag
  assert_rename_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_dst_we && iss_dst != '0 && !flush) |=>
      (iss_src_a != $past(iss_dst) ||
       (bcast_valid && bcast_tag == $past(iss_tag)) ||
       (!src_a_ready && src_a_tag == $past(iss_tag))));

  logic unused_ok;
  assign unused_ok = ^{bcast_data, src_b_value};

endmodule

bind rst_rename_table rst_rename_table_chk #(
  .DATA_W (DATA_W),
  .TAG_W  (TAG_W),
  .IDX_W  (IDX_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .iss_valid   (iss_valid),
  .iss_dst_we  (iss_dst_we),
  .iss_src_a   (iss_src_a),
  .iss_src_b   (iss_src_b),
  .iss_dst     (iss_dst),
  .iss_tag     (iss_tag),
  .bcast_valid (bcast_valid),
  .bcast_tag   (bcast_tag),
  .bcast_data  (bcast_data),
  .src_a_ready (src_a_ready),
  .src_a_value (src_a_value),
  .src_a_tag   (src_a_tag),
  .src_b_ready (src_b_ready),
  .src_b_value (src_b_value),
  .src_b_tag   (src_b_tag)
);

// File: tb/rst_rename_table_tb.sv
module rst_rename_table_tb_top;

  localparam int NR = 8;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n, flush, iss_valid, iss_dst_we, bcast_valid;
  logic [IW-1:0] iss_src_a, iss_src_b, iss_dst;
  logic [TW-1:0] iss_tag, bcast_tag;
  logic [DW-1:0] bcast_data;
  logic          src_a_ready, src_b_ready;
  logic [DW-1:0] src_a_value, src_b_value;
  logic [TW-1:0] src_a_tag, src_b_tag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rst_rename_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_IDX_W(TW-1)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
    .iss_dst_we(iss_dst_we), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_dst(iss_dst), .iss_tag(iss_tag), .bcast_valid(bcast_valid),
    .bcast_tag(bcast_tag), .bcast_data(bcast_data),
    .src_a_ready(src_a_ready), .src_a_value(src_a_value), .src_a_tag(src_a_tag),
    .src_b_ready(src_b_ready), .src_b_value(src_b_value), .src_b_tag(src_b_tag)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk1(input string req, input logic rdy, input logic [DW-1:0] val,
                      input logic [TW-1:0] tg, input logic erdy,
                      input logic [DW-1:0] eval, input logic [TW-1:0] etag);
    bit ok;
    ok = (rdy == erdy) && (erdy ? (val == eval) : (tg == etag));
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: rdy=%0b val=%h tag=%h expected rdy=%0b val=%h tag=%h",
               req, rdy, val, tg, erdy, eval, etag);
    end
  endtask

  // read register r on both ports and compare
  task automatic rd(input string req, input int r, input logic erdy,
                    input logic [DW-1:0] eval, input logic [TW-1:0] etag);
    iss_src_a = IW'(r);
    iss_src_b = IW'(r);
    #1;
    chk1(req, src_a_ready, src_a_value, src_a_tag, erdy, eval, etag);
    chk1(req, src_b_ready, src_b_value, src_b_tag, erdy, eval, etag);
  endtask

  task automatic issue(input int d, input logic [TW-1:0] t);
    iss_valid = 1; iss_dst_we = 1; iss_dst = IW'(d); iss_tag = t;
    tick();
    iss_valid = 0; iss_dst_we = 0;
  endtask

  task automatic bc(input logic [TW-1:0] t, input logic [DW-1:0] d);
    bcast_valid = 1; bcast_tag = t; bcast_data = d;
    tick();
    bcast_valid = 0;
  endtask

  function automatic logic [TW-1:0] sweep_tag(input int r);
    return TW'(((r % 2) * 8) + r);
  endfunction

  initial begin
    rst_n = 0; flush = 0; iss_valid = 0; iss_dst_we = 0; bcast_valid = 0;
    iss_src_a = 0; iss_src_b = 0; iss_dst = 0; iss_tag = 0;
    bcast_tag = 0; bcast_data = 0;
    @(negedge clk); tick(); rst_n = 1;

    // R1: reset state
    for (int r = 0; r < NR; r++) rd("R1", r, 1, 0, 0);

    // R11 then R2: read in the rename cycle sees the old state
    for (int r = 1; r < NR; r++) begin
      iss_valid = 1; iss_dst_we = 1; iss_dst = IW'(r); iss_tag = TW'(r);
      rd("R11", r, 1, 0, 0);
      tick();
      iss_valid = 0; iss_dst_we = 0;
      rd("R2", r, 0, 0, TW'(r));
    end

    // R7 bypass on odd registers, then R4 after the edge
    for (int r = 1; r < NR; r += 2) begin
      bcast_valid = 1; bcast_tag = TW'(r); bcast_data = DW'(16'h100 + r);
      rd("R7", r, 1, DW'(16'h100 + r), 0);
      tick();
      bcast_valid = 0;
      rd("R4", r, 1, DW'(16'h100 + r), 0);
    end

    // R3 / R5: rename reg 2 again, stale broadcast dropped
    issue(2, 4'd13);
    rd("R3", 2, 0, 0, 4'd13);
    bcast_valid = 1; bcast_tag = 4'd2; bcast_data = 16'hDEAD;
    rd("R5", 2, 0, 0, 4'd13);
    tick(); bcast_valid = 0;
    rd("R5", 2, 0, 0, 4'd13);
    bc(4'd13, 16'h0055);
    rd("R5", 2, 1, 16'h0055, 0);

    // R6: epoch bit differs only
    bc(4'd12, 16'hBAD0);
    rd("R6", 4, 0, 0, 4'd4);
    bc(4'd4, 16'h0044);
    rd("R6", 4, 1, 16'h0044, 0);

    // R8: rename and matching broadcast on reg 6 in one cycle
    iss_valid = 1; iss_dst_we = 1; iss_dst = 3'd6; iss_tag = 4'd14;
    bcast_valid = 1; bcast_tag = 4'd6; bcast_data = 16'h0066;
    tick();
    iss_valid = 0; iss_dst_we = 0; bcast_valid = 0;
    rd("R8", 6, 0, 0, 4'd14);
    bc(4'd14, 16'h0077);
    rd("R8", 6, 1, 16'h0077, 0);

    // R10: register zero ignores rename and broadcast
    issue(0, 4'd1);
    rd("R10", 0, 1, 0, 0);
    bc(4'd1, 16'h1234);
    rd("R10", 0, 1, 0, 0);

    // R9: flush
    issue(3, 4'd11);
    issue(5, 4'd10);
    rd("R9", 3, 0, 0, 4'd11);
    flush = 1; iss_valid = 1; iss_dst_we = 1; iss_dst = 3'd1; iss_tag = 4'd9;
    tick();
    flush = 0; iss_valid = 0; iss_dst_we = 0;
    rd("R9", 1, 1, DW'(16'h101), 0);
    rd("R9", 3, 1, DW'(16'h103), 0);
    rd("R9", 5, 1, DW'(16'h105), 0);
    bc(4'd11, 16'h0999);
    rd("R9", 3, 1, DW'(16'h103), 0);

    // R4 sweep: rename all, retire in reverse order, read all after each
    for (int r = 1; r < NR; r++) issue(r, sweep_tag(r));
    for (int k = NR - 1; k >= 1; k--) begin
      bc(sweep_tag(k), DW'(k * 17));
      for (int r = 1; r < NR; r++) begin
        if (r >= k) rd("R4", r, 1, DW'(r * 17), 0);
        else        rd("R4", r, 0, 0, sweep_tag(r));
      end
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule